// File: doc/BRIEF.md
# MSK Symbol Synchronizer and Bit Detector

This block is the receive half of an all-digital minimum-shift-keyed link. The line is a 1-bit square wave. It carries a "1" symbol as two full cycles of a 10-tick carrier, in either polarity. It carries a "0" symbol as two and a half cycles of a faster 8-tick carrier. A local prescaler produces the sampling tick. A local divider produces the 10-tick carrier and its complement. The prescaler and the divider are separate submodules, so a transmitter on the same die can share them in half-duplex operation.

The block compares every sample with both carrier polarities at the same time. For each polarity it keeps a run of consecutive matches. The first time either run covers one full symbol (20 samples), the block declares symbol timing found and starts its symbol windows at that sample. Only "1" symbols can produce this lock. From then on, it decides one bit per 20-sample window. The bit is "1" when every sample of the window agrees with a single polarity, and "0" otherwise. Each decision is marked by a one-cycle strobe. A full-length run that completes while locked pulls the window boundary onto that point.

Top module: `msk_sync_detect`

## Requirements
- R1: An active-low `rst_n` asynchronously forces `sync_ok`, `bit_stb` and `bit_out` to 0 and clears all counters; internal release happens on the second rising clock edge after `rst_n` goes high.
- R2: The line is sampled on every PRESCALE-th rising edge; sample 0 is taken on rising edge PRESCALE+2 counted from the release of `rst_n`.
- R3: The in-phase reference is high for carrier phases 0 to CAR_TICKS/2-1 and low for the rest; the carrier phase of sample n is n mod CAR_TICKS; the inverted reference is its complement, and either polarity can achieve lock.
- R4: Each polarity has a run counter that advances on a matching sample, returns to zero on a mismatching sample, and restarts from zero after reaching SYM_TICKS; a hit is a run reaching SYM_TICKS.
- R5: `sync_ok` rises on the clock edge that samples the first hit after reset and stays high until reset.
- R6: A line held constant at either level never produces lock.
- R7: No `bit_stb` occurs before `sync_ok`; the symbol that produced lock is not reported.
- R8: While locked, exactly one `bit_stb` is produced per window, on the edge sampling the window's last sample; a window is SYM_TICKS samples counted from the sample after lock or after the latest hit.
- R9: A window's bit is 1 only if all its samples match the in-phase reference, or all match the inverted one; a window that switches polarity, or carries the 8-tick carrier, gives 0.
- R10: A hit while locked ends the current window at that sample, strobes a 1, and starts a new window.
- R11: `bit_stb` lasts one clock; `bit_out` holds the last decided bit between strobes.
- R12: A stream sent with symbol starts on carrier phase 0 is recovered bit for bit after its in-phase "1" preamble, when the line is idle high before the preamble and each symbol's last sample mismatches the polarity of a following "1".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Received square-wave line, synchronous to clk |
| sync_ok | output | 1 | Symbol timing acquired |
| bit_stb | output | 1 | One-cycle strobe per decided bit |
| bit_out | output | 1 | Decided bit, valid at bit_stb and held afterwards |

## Verification
The bench targets the conditions a near-miss design gets wrong:
- A constant idle level and a run of 19 matches broken by one flipped sample must not lock; an off-by-one run counter would lock early, or never recover.
- A preamble of either polarity must lock on exactly the 20th sample. A design that ignores the inverted reference misses the second case, and one that keeps its count through a mismatch locks early.
- A symbol that switches polarity halfway must decode as 0, not 1.
- A run that completes off the window grid must emit an extra 1 and shift all later windows; a design that does not re-align keeps decoding on the stale grid.

// File: rtl/msk_rx_pkg.sv
package msk_rx_pkg;
  // Polarity indices of the two carrier references
  localparam int IDX_IP  = 0;
  localparam int IDX_INV = 1;
  localparam int NPOL    = 2;
endpackage

// File: rtl/msk_tick_gen.sv
module msk_tick_gen #(
  parameter int PRESCALE = 4  // clocks per sample tick, at least 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: ticks are isolated single cycles
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/msk_ref_carrier.sv
module msk_ref_carrier
  import msk_rx_pkg::*;
#(
  parameter int CAR_TICKS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [NPOL-1:0] ref_lvl
);
  localparam int PHW  = $clog2(CAR_TICKS);
  localparam int HALF = CAR_TICKS / 2;
  localparam logic [PHW-1:0] PH_LAST = PHW'(CAR_TICKS - 1);

  logic [PHW-1:0] phase_q, phase_d;
  logic           ip_lvl;

  always_comb begin
    phase_d = phase_q;
    if (tick) phase_d = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    ip_lvl           = (phase_q < PHW'(HALF));
    ref_lvl[IDX_IP]  = ip_lvl;
    ref_lvl[IDX_INV] = ~ip_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R3: phase moves only on a tick and wraps after the last phase
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q));
  p_phase_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase_q == PH_LAST) |=> (phase_q == '0));
endmodule

// File: rtl/msk_run_counter.sv
module msk_run_counter #(
  parameter int SYM_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match,
  output logic hit
);
  localparam int SW = $clog2(SYM_TICKS);
  localparam logic [SW-1:0] RUN_LAST = SW'(SYM_TICKS - 1);

  logic [SW-1:0] run_q, run_d;

  always_comb begin
    hit   = tick && match && (run_q == RUN_LAST);
    run_d = run_q;
    if (tick) begin
      if (!match || hit) run_d = '0;
      else               run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R4: a mismatching sample empties the run
  p_run_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !match) |=> (run_q == '0));
endmodule

// File: rtl/msk_sym_decider.sv
module msk_sym_decider
  import msk_rx_pkg::*;
#(
  parameter int SYM_TICKS = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NPOL-1:0] match,
  input  logic [NPOL-1:0] hit,
  output logic            sync_ok,
  output logic            bit_stb,
  output logic            bit_out
);
  localparam int PW = $clog2(SYM_TICKS);
  localparam logic [PW-1:0] POS_LAST = PW'(SYM_TICKS - 1);

  logic            sync_q, sync_d;
  logic [PW-1:0]   pos_q, pos_d;
  logic [NPOL-1:0] all_q, all_d, win_now;
  logic            stb_q, stb_d, bit_q, bit_d;
  logic            any_hit, win_end;

  always_comb begin
    any_hit = |hit;
    win_now = all_q & match;
    win_end = any_hit || (pos_q == POS_LAST);
    sync_d  = sync_q;
    pos_d   = pos_q;
    all_d   = all_q;
    stb_d   = 1'b0;
    bit_d   = bit_q;
    if (tick) begin
      if (any_hit) sync_d = 1'b1;
      if (win_end) begin
        pos_d = '0;
        all_d = '1;
      end else begin
        pos_d = pos_q + 1'b1;
        all_d = win_now;
      end
      if (sync_q && win_end) begin
        stb_d = 1'b1;
        bit_d = any_hit || (|win_now);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      pos_q  <= '0;
      all_q  <= '1;
      stb_q  <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      pos_q  <= pos_d;
      all_q  <= all_d;
      stb_q  <= stb_d;
      bit_q  <= bit_d;
    end
  end

  assign sync_ok = sync_q;
  assign bit_stb = stb_q;
  assign bit_out = bit_q;

  // R5: lock is sticky until reset
  p_sync_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> sync_q);
  // R7: the locking symbol produces no strobe
  p_lock_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> !stb_q);
  // R8: strobes follow a sampling tick
  p_stb_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(tick));
  // R10: a hit while locked reports a 1
  p_realign_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sync_q && any_hit) |=> (stb_q && bit_q));
  // R11: strobe is a single cycle
  p_stb_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
endmodule

// File: rtl/msk_sync_detect.sv
module msk_sync_detect
  import msk_rx_pkg::*;
#(
  parameter int PRESCALE  = 4,
  parameter int SYM_TICKS = 20,
  parameter int CAR_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic sync_ok,
  output logic bit_stb,
  output logic bit_out
);
  logic            rst_s1, rst_q_n;
  logic            tick;
  logic [NPOL-1:0] ref_lvl, match, hit;

  // Reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_q_n <= rst_s1;
    end
  end

  msk_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk   (clk),
    .rst_n (rst_q_n),
    .tick  (tick)
  );

  msk_ref_carrier #(.CAR_TICKS(CAR_TICKS)) u_car (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .tick    (tick),
    .ref_lvl (ref_lvl)
  );

  always_comb begin
    for (int p = 0; p < NPOL; p++) match[p] = (line_in == ref_lvl[p]);
  end

  for (genvar p = 0; p < NPOL; p++) begin : g_pol
    msk_run_counter #(.SYM_TICKS(SYM_TICKS)) u_run (
      .clk   (clk),
      .rst_n (rst_q_n),
      .tick  (tick),
      .match (match[p]),
      .hit   (hit[p])
    );
  end

  msk_sym_decider #(.SYM_TICKS(SYM_TICKS)) u_dec (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .tick    (tick),
    .match   (match),
    .hit     (hit),
    .sync_ok (sync_ok),
    .bit_stb (bit_stb),
    .bit_out (bit_out)
  );
endmodule

// File: tb/test_msk_sync_detect.sv
module test_msk_sync_detect;
  localparam int P   = 4;
  localparam int SYM = 20;
  localparam int CAR = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic line_in;
  logic sync_ok, bit_stb, bit_out;

  always #5 clk = ~clk;

  msk_sync_detect #(.PRESCALE(P), .SYM_TICKS(SYM), .CAR_TICKS(CAR)) i_msk_sync_detect (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .sync_ok(sync_ok), .bit_stb(bit_stb), .bit_out(bit_out)
  );

  int n_run = 0, n_fail = 0;
  bit q[$];
  int stb_seen, stb_exp;
  bit direct;
  string cur_req = "R9";

  // reference model state
  int samp_idx, l_ip, l_inv, win_len, first_sync;
  bit w_ip, w_inv, m_sync, prev_stb;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected bits as strobes appear
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (bit_stb) begin
        stb_seen++;
        chk(!prev_stb, "R11", "strobe longer than one cycle", 1, 0);
        if (q.size() == 0) chk(1'b0, cur_req, "unexpected strobe", 1, 0);
        else begin
          bit e;
          e = q.pop_front();
          chk(bit_out == e, cur_req, "decided bit", int'(bit_out), int'(e));
        end
      end
      prev_stb = bit_stb;
    end else prev_stb = 1'b0;
  end

  task automatic model_step(input bit v);
    bit rf, mi, mv, hit;
    rf = ((samp_idx % CAR) < CAR / 2);
    mi = (v == rf);
    mv = !mi;
    l_ip  = mi ? l_ip + 1 : 0;
    l_inv = mv ? l_inv + 1 : 0;
    hit = (mi && (l_ip % SYM == 0)) || (mv && (l_inv % SYM == 0));
    if (m_sync) begin
      win_len++;
      w_ip  = w_ip & mi;
      w_inv = w_inv & mv;
      if (hit || win_len == SYM) begin
        stb_exp++;
        if (!direct) q.push_back(hit || w_ip || w_inv);
        win_len = 0; w_ip = 1'b1; w_inv = 1'b1;
      end
    end else if (hit) begin
      m_sync = 1'b1;
      win_len = 0; w_ip = 1'b1; w_inv = 1'b1;
    end
    samp_idx++;
  endtask

  task automatic send_sample(input bit v);
    line_in = v;
    repeat (P) @(posedge clk);
    model_step(v);
    @(negedge clk);
    #1;
    chk(sync_ok == m_sync, "R5", "sync_ok", int'(sync_ok), int'(m_sync));
    if (!m_sync) chk(stb_seen == 0, "R7", "strobe before lock", stb_seen, 0);
    else chk(stb_seen == stb_exp, "R8", "strobe count", stb_seen, stb_exp);
    if (sync_ok && first_sync < 0) first_sync = samp_idx - 1;
  endtask

  task automatic send_idle(input bit v, input int n);
    for (int i = 0; i < n; i++) send_sample(v);
  endtask

  task automatic send_one(input bit pol, input int n);
    for (int k = 0; k < n; k++) send_sample(bit'((samp_idx % CAR) < CAR / 2) ^ pol);
  endtask

  task automatic send_zero(input bit lvl);
    for (int k = 0; k < SYM; k++) send_sample(lvl ^ bit'((k / 4) % 2));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!sync_ok && !bit_stb && !bit_out, "R1", "outputs in reset",
        int'({sync_ok, bit_stb, bit_out}), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    q.delete();
    stb_seen = 0; stb_exp = 0; samp_idx = 0; l_ip = 0; l_inv = 0;
    win_len = 0; w_ip = 1'b1; w_inv = 1'b1; m_sync = 1'b0; first_sync = -1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    chk(!sync_ok && !bit_stb && !bit_out, "R1", "outputs after release",
        int'({sync_ok, bit_stb, bit_out}), 0);
  endtask

  initial begin
    bit tx_b[11] = '{1, 1, 0, 1, 1, 0, 0, 1, 1, 1, 0};
    bit tx_p[11] = '{0, 0, 0, 1, 0, 0, 0, 0, 1, 1, 0};
    rst_n = 1'b0;
    line_in = 1'b1;
    direct = 1'b0;

    // constant line never locks (R6)
    do_reset();
    send_idle(1'b1, 100);
    send_idle(1'b0, 100);
    chk(!sync_ok, "R6", "lock on constant line", int'(sync_ok), 0);

    // aligned round trip with in-phase preamble (R2, R12)
    do_reset();
    direct = 1'b1;
    cur_req = "R12";
    send_idle(1'b1, 10);
    send_one(1'b0, SYM);
    chk(first_sync == 29, "R2", "lock sample index", first_sync, 29);
    for (int i = 0; i < 11; i++) q.push_back(tx_b[i]);
    for (int i = 0; i < 11; i++) begin
      if (tx_b[i]) send_one(tx_p[i], SYM);
      else send_zero((i + 1 < 11 && tx_b[i+1]) ? !tx_p[i+1] : 1'b1);
    end
    chk(q.size() == 0, "R12", "bits left unreceived", q.size(), 0);
    direct = 1'b0;

    // inverted preamble locks too (R3)
    do_reset();
    send_idle(1'b0, 10);
    send_one(1'b1, SYM);
    chk(first_sync == 29, "R3", "lock on inverted carrier", first_sync, 29);

    // broken run restarts the count (R4)
    do_reset();
    send_idle(1'b1, 10);
    send_one(1'b0, 19);
    send_sample(1'b1);
    send_one(1'b0, SYM);
    chk(first_sync == 49, "R4", "lock after broken run", first_sync, 49);

    // polarity switch inside a window, then off-grid run (R9, R10)
    do_reset();
    cur_req = "R9";
    send_idle(1'b1, 10);
    send_one(1'b0, SYM);
    send_one(1'b0, SYM);
    send_one(1'b0, 10);
    send_one(1'b1, 10);
    cur_req = "R10";
    for (int k = 0; k < 8; k++) send_sample(bit'(k < 4));
    send_one(1'b0, 40);
    chk(stb_seen == 5, "R10", "strobes incl. realign", stb_seen, 5);

    // reset while locked drops everything (R1)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!sync_ok && !bit_stb, "R1", "async drop while locked",
        int'({sync_ok, bit_stb}), 0);
    do_reset();
    send_idle(1'b1, 10);
    chk(!sync_ok, "R1", "no lock after reset", int'(sync_ok), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule